// File: doc/BRIEF.md
# Queued Input Capture Unit

This block timestamps edges on four input pins against a free-running counter. Each channel has its own edge selector and a capture register. When queue operation is selected, a holding register sits behind each capture register, so a channel can keep two timestamps before software must service it. A per-channel protect bit stops unread timestamps from being lost. A paired flagging option raises a channel's flag only once both of its registers are occupied, so software is interrupted once for every two captures instead of once for every capture.

A control register can route one pin to a second channel. Channel y can then be triggered by the pin of channel (y+2) mod 4 in addition to its own pin. Software reaches all state through a flat register port. Reads return data in the same cycle and take effect on the following clock edge. The control register can be locked after its first write when the lock input is high.

Top module: `qcap_unit`

## Requirements
- R1: After reset, every register reads 0 (control at address 0, edge select at 1, protect at 2, flags at 3, enables at 4, capture i at 8+i, holding i at 12+i), and `irq_o` is low.
- R2: Edge select for channel i is bits [2i+1:2i] of address 1: 00 means off, 01 means rising, 10 means falling, 11 means both edges. A matching edge on a pin that changes before clock edge k loads the counter value from just before edge k into the capture register, plus 2.
- R3: Queue operation is control bit 0. When it is set, a capture first moves an occupied capture value into the holding register. When it is clear, the holding register is never written.
- R4: Reading capture i or holding i through `bus_rd` marks that register as empty. The value stays readable. If a capture lands in the same cycle, the capture wins.
- R5: With protect bit i set at address 2, an event is dropped when the capture register is occupied and, in queue operation, the holding register is also occupied. Stored values do not change.
- R6: With protect bit i clear, every selected event is accepted and overwrites the older queued values.
- R7: With control bit 3, control bit 0 and protect bit i all set, flag i is raised only by a capture that leaves both registers of channel i occupied.
- R8: Otherwise, every accepted capture sets flag i (address 3). Writing 1 to a flag bit clears it, unless a capture sets it in the same cycle.
- R9: `irq_o` is high exactly when some flag bit and its enable bit (address 4) are both 1.
- R10: Control bit 4+x makes an edge on pin x also trigger channel (x+2) mod 4, using the edge selection of pin x.
- R11: While `wr_once_mode` is high, a control write is accepted only if no control write has been accepted since reset. While it is low, every control write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_once_mode | input | 1 | High: control register may be written once after reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes capture/holding data) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cap_pin | input | 4 | Asynchronous capture inputs |
| flag_o | output | 4 | Per-channel capture flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench aims at the third event on a protected channel whose queue is full. A design that dropped protection would replace the oldest stamp, and one that ignored the holding register would keep only one value. Paired flagging is tested by capturing into emptied registers. A design that flags on every capture would raise the interrupt one capture early. Pin sharing is tested with the target channel's own edge detector turned off. A wrong source mapping, or gating by the target's edge select, would leave the target register unchanged. The once-only control lock is also tested: a design that ignores the lock would show the second written value.

// File: rtl/qcap_pkg.sv
package qcap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   // control bit positions
   localparam int unsigned CB_QUEUE  = 0;
   localparam int unsigned CB_BUFEN  = 1;
   localparam int unsigned CB_ACCMUX = 2;
   localparam int unsigned CB_PAIRED = 3;
   localparam int unsigned CB_SHARE  = 4;

   // register addresses
   localparam logic [3:0] RA_CTRL = 4'd0;
   localparam logic [3:0] RA_EDGE = 4'd1;
   localparam logic [3:0] RA_PROT = 4'd2;
   localparam logic [3:0] RA_FLAG = 4'd3;
   localparam logic [3:0] RA_IEN  = 4'd4;
   localparam logic [3:0] RA_CNT  = 4'd5;
   localparam logic [3:0] RA_CAP  = 4'd8;
   localparam logic [3:0] RA_HOLD = 4'd12;
endpackage

// File: rtl/qcap_edge_det.sv
module qcap_edge_det
   import qcap_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      det
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qcap_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   always_comb begin
      cur  = sync_q[SYNC_STAGES-1];
      rise = cur & ~prev_q;
      fall = ~cur & prev_q;
      unique case (sel)
         EDGE_RISE: det = rise;
         EDGE_FALL: det = fall;
         EDGE_ANY:  det = rise | fall;
         default:   det = 1'b0;
      endcase
   end
endmodule

// File: rtl/qcap_chan.sv
module qcap_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic             queue_mode,
   input  logic             protect,
   input  logic             paired,
   input  logic [CNT_W-1:0] cnt,
   input  logic             rd_cap,
   input  logic             rd_hold,
   output logic [CNT_W-1:0] cap_o,
   output logic [CNT_W-1:0] hold_o,
   output logic             cap_full_o,
   output logic             hold_full_o,
   output logic             flag_set_o
);
   logic [CNT_W-1:0] cap_q, hold_q;
   logic             cap_full_q, hold_full_q;
   logic             cap_f, hold_f, blocked, take, move;
   logic             cap_full_d, hold_full_d, pair_mode;

   always_comb begin
      // a read in this cycle empties the register before any event
      cap_f       = cap_full_q & ~rd_cap;
      hold_f      = hold_full_q & ~rd_hold;
      blocked     = protect & cap_f & (hold_f | ~queue_mode);
      take        = ev & ~blocked;
      move        = take & queue_mode & cap_f;
      cap_full_d  = take | cap_f;
      hold_full_d = move | hold_f;
      pair_mode   = paired & queue_mode & protect;
      flag_set_o  = take & (~pair_mode | hold_full_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q       <= '0;
         hold_q      <= '0;
         cap_full_q  <= 1'b0;
         hold_full_q <= 1'b0;
      end else begin
         if (move) hold_q <= cap_q;
         if (take) cap_q  <= cnt;
         cap_full_q  <= cap_full_d;
         hold_full_q <= hold_full_d;
      end
   end

   assign cap_o       = cap_q;
   assign hold_o      = hold_q;
   assign cap_full_o  = cap_full_q;
   assign hold_full_o = hold_full_q;
endmodule

// File: rtl/qcap_ctrl_reg.sv
module qcap_ctrl_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   input  logic             once,
   output logic [WIDTH-1:0] q,
   output logic             written
);
   logic [WIDTH-1:0] q_r;
   logic             done_q;
   logic             accept;

   assign accept = we & (~once | ~done_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         done_q <= 1'b0;
      end else if (accept) begin
         q_r    <= wdata;
         done_q <= 1'b1;
      end
   end

   assign q       = q_r;
   assign written = done_q;
endmodule

// File: rtl/qcap_unit.sv
module qcap_unit
   import qcap_pkg::*;
#(
   parameter int unsigned NCH         = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_once_mode,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCH-1:0]    cap_pin,
   output logic [NCH-1:0]    flag_o,
   output logic              irq_o
);
   localparam int unsigned CTRL_W = CB_SHARE + NCH;
   localparam int unsigned HALF   = NCH / 2;
   localparam int unsigned EDGE_W = 2 * NCH;

   if (NCH % 2 != 0 || NCH > 4 || NCH < 2) begin : g_bad_nch
      $error("qcap_unit: NCH must be 2 or 4");
   end
   if (CNT_W > DATA_W || CTRL_W > DATA_W || EDGE_W > DATA_W) begin : g_bad_w
      $error("qcap_unit: DATA_W too narrow");
   end
   if (ADDR_W != 4) begin : g_bad_a
      $error("qcap_unit: ADDR_W must be 4");
   end

   logic [CNT_W-1:0]            cnt_q;
   logic [CTRL_W-1:0]           ctrl_q;
   logic                        ctrl_done;
   logic [EDGE_W-1:0]           edge_q;
   logic [NCH-1:0]              prot_q, ien_q, flag_q, flag_d, flag_set;
   logic [NCH-1:0]              det, ev, rd_cap, rd_hold, cap_full, hold_full;
   logic [NCH-1:0][CNT_W-1:0]   cap_v, hold_v;
   logic                        wr_ctrl, wr_flag;
   logic [DATA_W-1:0]           rdata_c;

   assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
   assign wr_flag = bus_wr && (bus_addr == RA_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   qcap_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_ctrl),
      .wdata   (bus_wdata[CTRL_W-1:0]),
      .once    (wr_once_mode),
      .q       (ctrl_q),
      .written (ctrl_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         prot_q <= '0;
         ien_q  <= '0;
         flag_q <= '0;
      end else begin
         if (bus_wr && bus_addr == RA_EDGE) edge_q <= bus_wdata[EDGE_W-1:0];
         if (bus_wr && bus_addr == RA_PROT) prot_q <= bus_wdata[NCH-1:0];
         if (bus_wr && bus_addr == RA_IEN)  ien_q  <= bus_wdata[NCH-1:0];
         flag_q <= flag_d;
      end
   end

   always_comb begin
      flag_d = (flag_q & ~(wr_flag ? bus_wdata[NCH-1:0] : {NCH{1'b0}})) | flag_set;
   end

   for (genvar y = 0; y < NCH; y++) begin : g_ch
      localparam int unsigned SRC = (y + HALF) % NCH;

      qcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (cap_pin[y]),
         .sel   (edge_sel_e'(edge_q[2*y +: 2])),
         .det   (det[y])
      );

      assign ev[y]      = det[y] | (ctrl_q[CB_SHARE + SRC] & det[SRC]);
      assign rd_cap[y]  = bus_rd && (bus_addr == RA_CAP  + 4'(y));
      assign rd_hold[y] = bus_rd && (bus_addr == RA_HOLD + 4'(y));

      qcap_chan #(.CNT_W(CNT_W)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .ev          (ev[y]),
         .queue_mode  (ctrl_q[CB_QUEUE]),
         .protect     (prot_q[y]),
         .paired      (ctrl_q[CB_PAIRED]),
         .cnt         (cnt_q),
         .rd_cap      (rd_cap[y]),
         .rd_hold     (rd_hold[y]),
         .cap_o       (cap_v[y]),
         .hold_o      (hold_v[y]),
         .cap_full_o  (cap_full[y]),
         .hold_full_o (hold_full[y]),
         .flag_set_o  (flag_set[y])
      );
   end

   always_comb begin
      rdata_c = '0;
      unique case (bus_addr)
         RA_CTRL: rdata_c = DATA_W'(ctrl_q);
         RA_EDGE: rdata_c = DATA_W'(edge_q);
         RA_PROT: rdata_c = DATA_W'(prot_q);
         RA_FLAG: rdata_c = DATA_W'(flag_q);
         RA_IEN:  rdata_c = DATA_W'(ien_q);
         RA_CNT:  rdata_c = DATA_W'(cnt_q);
         default: rdata_c = '0;
      endcase
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == RA_CAP  + 4'(i)) rdata_c = DATA_W'(cap_v[i]);
         if (bus_addr == RA_HOLD + 4'(i)) rdata_c = DATA_W'(hold_v[i]);
      end
   end

   assign bus_rdata = rdata_c;
   assign flag_o    = flag_q;
   assign irq_o     = |(flag_q & ien_q);
endmodule

// File: rtl/qcap_chk.sv
module qcap_chk
   import qcap_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CTRL_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_once_mode,
   input logic                      bus_wr,
   input logic                      bus_rd,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [CTRL_W-1:0]         ctrl_q,
   input logic                      ctrl_done,
   input logic [NCH-1:0]            prot_q,
   input logic [NCH-1:0]            ien_q,
   input logic [NCH-1:0]            flag_o,
   input logic [NCH-1:0]            flag_set,
   input logic [NCH-1:0]            ev,
   input logic [NCH-1:0]            cap_full,
   input logic [NCH-1:0]            hold_full,
   input logic [NCH-1:0][CNT_W-1:0] cap_v,
   input logic [NCH-1:0][CNT_W-1:0] hold_v,
   input logic                      irq_o
);
   // R11: locked control register keeps its value
   p_ctrl_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_once_mode && ctrl_done && bus_wr && bus_addr == RA_CTRL) |=> $stable(ctrl_q));

   // R3: latch operation leaves holding registers untouched
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_QUEUE] |=> $stable(hold_v));

   // R8: write-one clears a flag absent a simultaneous capture
   p_flag_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_FLAG && flag_set == '0) |=>
         ((flag_o & $past(bus_wdata[NCH-1:0])) == '0));

   // R9: no enabled flag, no interrupt
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_o & ien_q) == '0) |-> !irq_o);

   for (genvar i = 0; i < NCH; i++) begin : g_p
      // R5: a full protected queue is frozen
      p_prot_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (prot_q[i] && ctrl_q[CB_QUEUE] && cap_full[i] && hold_full[i] &&
          !(bus_rd && (bus_addr == RA_CAP + 4'(i) || bus_addr == RA_HOLD + 4'(i))))
         |=> ($stable(cap_v[i]) && $stable(hold_v[i])));

      // R4: reading a holding register empties it
      p_hold_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == RA_HOLD + 4'(i) && !ev[i]) |=> !hold_full[i]);
   end
endmodule

bind qcap_unit qcap_chk #(
   .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_once_mode (wr_once_mode),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .ctrl_q       (ctrl_q),
   .ctrl_done    (ctrl_done),
   .prot_q       (prot_q),
   .ien_q        (ien_q),
   .flag_o       (flag_o),
   .flag_set     (flag_set),
   .ev           (ev),
   .cap_full     (cap_full),
   .hold_full    (hold_full),
   .cap_v        (cap_v),
   .hold_v       (hold_v),
   .irq_o        (irq_o)
);

// File: tb/qcap_unit_tb_top.sv
module qcap_unit_tb_top;
   import qcap_pkg::*;

   logic        clk = 1'b0, rst_n = 1'b0, once = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  pins = '0;
   logic [3:0]  flags;
   logic        irq;

   always #2 clk = ~clk;

   qcap_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wr_once_mode(once), .bus_wr(wr), .bus_rd(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .cap_pin(pins),
      .flag_o(flags), .irq_o(irq)
   );

   int checks = 0, errors = 0;
   logic [15:0] m_cap [4];
   logic [15:0] m_hold[4];
   logic [3:0]  m_cf, m_hf, m_flag, m_prot, m_ien;
   logic [7:0]  m_ctrl, m_edge;
   logic        m_done;

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 4; i++) begin m_cap[i] = '0; m_hold[i] = '0; end
      m_cf = '0; m_hf = '0; m_flag = '0; m_prot = '0; m_ien = '0;
      m_ctrl = '0; m_edge = '0; m_done = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pins = '0; wr = 1'b0; rd = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
   endtask

   task automatic wr_reg(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      case (a)
         RA_CTRL: if (!once || !m_done) begin m_ctrl = d[7:0]; m_done = 1'b1; end
         RA_EDGE: m_edge = d[7:0];
         RA_PROT: m_prot = d[3:0];
         RA_IEN:  m_ien  = d[3:0];
         RA_FLAG: m_flag = m_flag & ~d[3:0];
         default: ;
      endcase
   endtask

   task automatic rd_reg(logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
      if (a >= RA_CAP && a < RA_CAP + 4)  m_cf[a - RA_CAP]  = 1'b0;
      if (a >= RA_HOLD)                   m_hf[a - RA_HOLD] = 1'b0;
   endtask

   task automatic peek(string req, logic [3:0] a, logic [15:0] exp);
      @(negedge clk);
      addr = a;
      #1 chk(req, rdata, exp);
   endtask

   task automatic check_cap(int i, string req);
      logic [15:0] v;
      rd_reg(RA_CAP + 4'(i), v);
      chk(req, v, m_cap[i]);
   endtask

   task automatic check_hold(int i, string req);
      logic [15:0] v;
      rd_reg(RA_HOLD + 4'(i), v);
      chk(req, v, m_hold[i]);
   endtask

   task automatic check_flags(string req);
      peek(req, RA_FLAG, {12'b0, m_flag});
      chk(req, {15'b0, irq}, {15'b0, |(m_flag & m_ien)});
   endtask

   task automatic model_event(int i, logic [15:0] val);
      logic q, blocked, paired;
      q       = m_ctrl[CB_QUEUE];
      blocked = m_prot[i] & m_cf[i] & (m_hf[i] | ~q);
      if (blocked) return;
      paired = m_ctrl[CB_PAIRED] & q & m_prot[i];
      if (q && m_cf[i]) begin m_hold[i] = m_cap[i]; m_hf[i] = 1'b1; end
      m_cap[i] = val; m_cf[i] = 1'b1;
      if (!paired || m_hf[i]) m_flag[i] = 1'b1;
   endtask

   task automatic drive_pins(logic [3:0] nv);
      logic [15:0] c;
      logic [3:0]  old, det;
      @(negedge clk);
      addr = RA_CNT;
      #1 c = rdata;
      old  = pins;
      pins = nv;
      repeat (3) @(negedge clk);
      for (int x = 0; x < 4; x++) begin
         case (m_edge[2*x +: 2])
            2'b01:   det[x] = nv[x] & ~old[x];
            2'b10:   det[x] = ~nv[x] & old[x];
            2'b11:   det[x] = nv[x] ^ old[x];
            default: det[x] = 1'b0;
         endcase
      end
      for (int y = 0; y < 4; y++) begin
         int src;
         src = (y + 2) % 4;
         if (det[y] || (m_ctrl[CB_SHARE + src] && det[src])) model_event(y, c + 16'd2);
      end
   endtask

   task automatic toggle(int p);
      drive_pins(pins ^ (4'b1 << p));
   endtask

   task automatic empty_ch(int i);
      logic [15:0] v;
      rd_reg(RA_CAP + 4'(i), v);
      rd_reg(RA_HOLD + 4'(i), v);
   endtask

   initial begin
      void'($urandom(32'd2024));
      model_clear();
      do_reset();

      // R1: reset state
      peek("R1", RA_CTRL, 16'h0);
      peek("R1", RA_EDGE, 16'h0);
      peek("R1", RA_FLAG, 16'h0);
      peek("R1", RA_PROT, 16'h0);
      check_cap(0, "R1");
      check_hold(3, "R1");
      chk("R1", {15'b0, irq}, 16'h0);

      wr_reg(RA_IEN, 16'hF);
      wr_reg(RA_CTRL, 16'h01);

      // R2: edge encodings and timestamp
      wr_reg(RA_EDGE, 16'h55);
      drive_pins(4'b0001);
      check_cap(0, "R2");
      wr_reg(RA_FLAG, 16'hF);
      drive_pins(4'b0000);
      check_flags("R2");
      wr_reg(RA_EDGE, 16'h56);
      drive_pins(4'b0001);
      check_flags("R2");
      drive_pins(4'b0000);
      check_cap(0, "R2");
      wr_reg(RA_EDGE, 16'hFF);
      drive_pins(4'b0001);
      check_cap(0, "R2");

      // R3: queue movement and latch operation
      toggle(1); toggle(1);
      check_hold(1, "R3");
      check_cap(1, "R3");
      wr_reg(RA_CTRL, 16'h00);
      toggle(1);
      check_hold(1, "R3");
      check_cap(1, "R3");
      wr_reg(RA_CTRL, 16'h01);

      // R5 / R4: protection and read-to-empty
      empty_ch(2);
      wr_reg(RA_PROT, 16'h4);
      toggle(2); toggle(2); toggle(2);
      check_hold(2, "R5");
      check_cap(2, "R5");
      toggle(2);
      check_cap(2, "R4");
      check_hold(2, "R4");

      // R6: overwrite without protection
      wr_reg(RA_PROT, 16'h0);
      toggle(3); toggle(3); toggle(3);
      check_hold(3, "R6");
      check_cap(3, "R6");

      // R7: paired flagging
      wr_reg(RA_CTRL, 16'h09);
      wr_reg(RA_PROT, 16'hF);
      empty_ch(0);
      wr_reg(RA_FLAG, 16'hF);
      toggle(0);
      check_flags("R7");
      toggle(0);
      check_flags("R7");

      // R8: every capture flags, write-one clear
      wr_reg(RA_CTRL, 16'h01);
      wr_reg(RA_PROT, 16'h0);
      wr_reg(RA_FLAG, 16'hF);
      toggle(1);
      check_flags("R8");
      wr_reg(RA_FLAG, 16'h2);
      check_flags("R8");

      // R9: enable gating
      wr_reg(RA_IEN, 16'h0);
      toggle(1);
      check_flags("R9");
      wr_reg(RA_IEN, 16'hF);
      check_flags("R9");

      // R10: pin sharing with target detector off
      wr_reg(RA_EDGE, 16'h03);
      wr_reg(RA_CTRL, 16'h11);
      empty_ch(2);
      toggle(0);
      check_cap(2, "R10");
      wr_reg(RA_CTRL, 16'h01);
      toggle(0);
      check_cap(2, "R10");

      // random mix
      for (int n = 0; n < 500; n++) begin
         int op;
         if (n % 50 == 0) begin
            wr_reg(RA_EDGE, 16'($urandom));
            wr_reg(RA_CTRL, 16'($urandom) & 16'h00F9 | 16'h0100);
            wr_reg(RA_PROT, 16'($urandom));
         end
         op = $urandom % 7;
         case (op)
            0, 1, 2: toggle($urandom % 4);
            3:       check_cap($urandom % 4, "R3");
            4:       check_hold($urandom % 4, "R5");
            5:       check_flags("R8");
            default: wr_reg(RA_FLAG, 16'($urandom % 16));
         endcase
      end

      // R11: write-once control lock
      once = 1'b1;
      do_reset();
      wr_reg(RA_CTRL, 16'h01);
      wr_reg(RA_CTRL, 16'h08);
      peek("R11", RA_CTRL, {8'b0, m_ctrl});
      chk("R11", {8'b0, m_ctrl}, 16'h01);
      once = 1'b0;
      wr_reg(RA_CTRL, 16'h08);
      peek("R11", RA_CTRL, 16'h08);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule